// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block places a direct-mapped cache between a processor port and a slower memory that transfers one word per handshake. With default parameters it holds 1024 lines, each four 32-bit words wide. Each line carries a valid flag and an 18-bit tag. Every processor access looks up exactly one line, chosen by the index field of its byte address.

A read that finds a valid line with a matching tag completes in the same cycle. Any other access stalls the processor while the whole line is fetched one word at a time, installed, and then replayed, so that it finishes as a hit. Stores are written through to memory. A store that misses first allocates the line and then merges its word.

For every completed access, a status output reports one of three outcomes: a hit, a miss on an empty line, or a miss that evicted a different block. Lines are never dirty, so an eviction simply drops the old contents.

Top module: `dm_cache`

## Requirements
- R1: A byte address is split into tag = bits 31:14, index = bits 13:4, word select = bits 3:2; bits 1:0 are ignored, so addresses differing only there return the same word.
- R2: After reset every line is empty: the first access to any line reports status 2'b10 (cold miss).
- R3: A read whose indexed line is valid with an equal tag raises cpu_ready_o in the same cycle as the request, with status 2'b01 and the stored word on cpu_rdata_o, and issues no memory request.
- R4: A miss on an invalid line reports status 2'b10 when the access completes.
- R5: A miss on a valid line whose tag differs reports status 2'b11; the old contents are discarded and no memory write is made for them.
- R6: A refill issues exactly four memory reads, at the block base plus 0x0, 0x4, 0x8 and 0xC in ascending order, and cpu_ready_o stays low throughout the refill.
- R7: After a refill the access is replayed and completes; a later read of the same block hits.
- R8: A store that hits issues one memory write at the word-aligned address carrying cpu_wdata_i; cpu_ready_o rises only in the cycle mem_ready_i acknowledges it, with status 2'b01, and later reads return the new word.
- R9: A store that misses first performs the four-word refill and then the single memory write, and reports the miss kind (2'b10 or 2'b11).
- R10: Read data always equals the current memory contents, whether or not the block was cached.
- R11: cpu_status_o is 2'b00 in every cycle in which no access completes.
- R12: While mem_req_o is high and mem_ready_i is low, the memory request (mem_addr_o, mem_we_o, mem_wdata_o) is held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request; held with its operands until cpu_ready_o |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_rdata_o | output | 32 | Load data, valid while cpu_ready_o is high |
| cpu_ready_o | output | 1 | Access completes this cycle |
| cpu_status_o | output | 2 | 00 none, 01 hit, 10 cold miss, 11 replacement miss |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory write when high |
| mem_addr_o | output | 32 | Word-aligned memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory acknowledges the request this cycle |

## Verification
The hardest case to reach is a replacement miss that immediately follows a refill of the same index, and in particular a store that evicts a line. The stimulus confines tags to four values and indices to six, including 0 and the top index, so random traffic keeps colliding on the same lines. It mixes these collisions with directed sequences that refill, hit, evict and re-read one index.

The memory responder inserts random wait states, which exercises the hold rule and the stall over many cycle alignments. Every operation the memory sees is logged and compared with the expected refill order and write-through.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;
  typedef enum logic [1:0] {
    ST_NONE    = 2'b00,
    ST_HIT     = 2'b01,
    ST_COLD    = 2'b10,
    ST_REPLACE = 2'b11
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_FILL  = 2'b01,
    S_WRITE = 2'b10
  } state_e;
endpackage

// File: rtl/dm_tag_store.sv
module dm_tag_store #(
  parameter int LINES = 1024,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];

  // R7: a line installed at the index being looked up reads back valid with its tag
  a_r7_install_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (rd_idx_i == wr_idx_i) |=> ($past(rd_idx_i) != rd_idx_i) ||
      (rd_valid_o && rd_tag_o == $past(wr_tag_i)));
endmodule

// File: rtl/dm_line_store.sv
module dm_line_store #(
  parameter int LINES  = 1024,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WSEL_W-1:0] rd_word_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WSEL_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [LINE_W-1:0] line_q [LINES];
  logic [LINE_W-1:0] rd_line;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) line_q[wr_idx_i][wr_word_i*DATA_W +: DATA_W] <= wr_data_i;
  end

  assign rd_line   = line_q[rd_idx_i];
  assign rd_data_o = rd_line[rd_word_i*DATA_W +: DATA_W];
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dm_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 1024,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WSEL_W = $clog2(WORDS),
  localparam int OFF_W  = BYTE_W + WSEL_W,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lk_valid_i,
  input  logic              lk_hit_i,
  output logic              ready_o,
  output logic [1:0]        status_o,
  output logic              tag_we_o,
  output logic              data_we_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [WSEL_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

  state_e                   st_q;
  status_e                  stat_q;
  logic                     replay_q;
  logic [WSEL_W-1:0]        cnt_q;
  logic [ADDR_W-1:BYTE_W]   addr_q;
  logic [DATA_W-1:0]        wdata_q;

  assign wr_idx_o  = addr_q[OFF_W +: IDX_W];
  assign wr_tag_o  = addr_q[ADDR_W-1 -: TAG_W];
  assign mem_wdata_o = wdata_q;

  always_comb begin
    ready_o    = 1'b0;
    status_o   = ST_NONE;
    tag_we_o   = 1'b0;
    data_we_o  = 1'b0;
    wr_word_o  = addr_q[BYTE_W +: WSEL_W];
    wr_data_o  = wdata_q;
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = {addr_q, {BYTE_W{1'b0}}};
    unique case (st_q)
      S_IDLE: begin
        if (req_i && lk_hit_i && !we_i) begin
          ready_o  = 1'b1;
          status_o = replay_q ? stat_q : ST_HIT;
        end
      end
      S_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {addr_q[ADDR_W-1:OFF_W], cnt_q, {BYTE_W{1'b0}}};
        wr_word_o  = cnt_q;
        wr_data_o  = mem_rdata_i;
        data_we_o  = mem_ready_i;
        tag_we_o   = mem_ready_i && (cnt_q == LAST_WORD);
      end
      S_WRITE: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        data_we_o = mem_ready_i;
        if (mem_ready_i) begin
          ready_o  = 1'b1;
          status_o = stat_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      stat_q   <= ST_NONE;
      replay_q <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (req_i) begin
            if (!lk_hit_i) begin
              stat_q   <= lk_valid_i ? ST_REPLACE : ST_COLD;
              replay_q <= 1'b1;
              addr_q   <= addr_i[ADDR_W-1:BYTE_W];
              wdata_q  <= wdata_i;
              cnt_q    <= '0;
              st_q     <= S_FILL;
            end else if (we_i) begin
              addr_q  <= addr_i[ADDR_W-1:BYTE_W];
              wdata_q <= wdata_i;
              if (!replay_q) stat_q <= ST_HIT;
              st_q    <= S_WRITE;
            end else begin
              replay_q <= 1'b0;
            end
          end
        end
        S_FILL: begin
          if (mem_ready_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_WORD) st_q <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (mem_ready_i) begin
            replay_q <= 1'b0;
            st_q     <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r12_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r6_fill_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ready_i && (mem_addr_o[OFF_W-1:BYTE_W] != LAST_WORD)
    |=> mem_req_o && !mem_we_o &&
      (mem_addr_o[OFF_W-1:BYTE_W] == $past(mem_addr_o[OFF_W-1:BYTE_W]) + 1'b1));

  a_r6_fill_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> !ready_o);

  a_r5_write_only_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> req_i && we_i);

  a_r8_store_done_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ready_i |-> ready_o && status_o != ST_NONE);

  a_r11_status_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && ready_o) |-> status_o == ST_NONE);

  a_r3_hit_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && !we_i |-> !mem_req_o);
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic [1:0]        cpu_status_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0]  cpu_tag, lk_tag, wr_tag;
  logic [IDX_W-1:0]  cpu_idx, wr_idx;
  logic [WSEL_W-1:0] cpu_word, wr_word;
  logic [DATA_W-1:0] wr_data;
  logic              lk_valid, lk_hit, tag_we, data_we;
  logic              unused_lsb;

  assign cpu_tag    = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_idx    = cpu_addr_i[OFF_W +: IDX_W];
  assign cpu_word   = cpu_addr_i[BYTE_W +: WSEL_W];
  assign unused_lsb = ^cpu_addr_i[BYTE_W-1:0];
  assign lk_hit     = lk_valid && (lk_tag == cpu_tag);

  dm_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) i_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(cpu_idx), .rd_valid_o(lk_valid), .rd_tag_o(lk_tag),
    .wr_en_i(tag_we), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag)
  );

  dm_line_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) i_lines (
    .clk_i,
    .rd_idx_i(cpu_idx), .rd_word_i(cpu_word), .rd_data_o(cpu_rdata_o),
    .wr_en_i(data_we), .wr_idx_i(wr_idx), .wr_word_i(wr_word), .wr_data_i(wr_data)
  );

  dm_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) i_ctrl (
    .clk_i, .rst_ni,
    .req_i(cpu_req_i), .we_i(cpu_we_i), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
    .lk_valid_i(lk_valid), .lk_hit_i(lk_hit),
    .ready_o(cpu_ready_o), .status_o(cpu_status_o),
    .tag_we_o(tag_we), .data_we_o(data_we),
    .wr_idx_o(wr_idx), .wr_tag_o(wr_tag), .wr_word_o(wr_word), .wr_data_o(wr_data),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ready_i
  );

  // R1: a completed load presents the word picked by bits 3:2 of the line
  a_r1_load_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o && !cpu_we_i |-> lk_hit && !$isunknown(cpu_rdata_o));
endmodule

// File: tb/test_dm_cache.sv
`timescale 1ns/100ps
module test_dm_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic [1:0]  cpu_status;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  dm_cache i_dm_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready), .cpu_status_o(cpu_status),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem_m [logic [29:0]];
  logic        ref_valid [1024];
  logic [17:0] ref_tag   [1024];
  logic [31:0] op_addr[$];
  logic        op_we[$];
  logic [31:0] op_data[$];

  function automatic logic [31:0] mem_rd(logic [29:0] wa);
    if (mem_m.exists(wa)) return mem_m[wa];
    return {wa, 2'b01} ^ 32'hA5C3_0F1E;
  endfunction

  function automatic logic [1:0] exp_status(logic [31:0] a);
    if (!ref_valid[a[13:4]]) return 2'b10;
    if (ref_tag[a[13:4]] != a[31:14]) return 2'b11;
    return 2'b01;
  endfunction

  task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // memory responder with random wait states
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) mem_ready = 1'b0;
      else if (mem_req) begin
        if (lat == 0) begin
          mem_ready = 1'b1;
          op_addr.push_back(mem_addr);
          op_we.push_back(mem_we);
          op_data.push_back(mem_wdata);
          if (mem_we) mem_m[mem_addr[31:2]] = mem_wdata;
          else mem_rdata = mem_rd(mem_addr[31:2]);
          lat = $urandom_range(0, 2);
        end else lat--;
      end
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic [1:0] st);
    logic [1:0]  es;
    logic [31:0] exp_rd;
    int n_exp, cyc;
    logic quiet_ok;
    es = exp_status(a);
    op_addr.delete(); op_we.delete(); op_data.delete();
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; quiet_ok = 1'b1;
    forever begin
      #1;
      if (cpu_ready) break;
      if (cpu_status != 2'b00) quiet_ok = 1'b0;
      @(negedge clk);
      cyc++;
      if (cyc > 200) begin
        check(1'b0, "watchdog", cyc, 200);
        break;
      end
    end
    rd = cpu_rdata; st = cpu_status;
    if (!we) exp_rd = mem_rd(a[31:2]);
    else exp_rd = '0;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    // R11: no status while stalled
    if (cyc > 0) check(quiet_ok, "R11 status quiet while stalled", {31'd0, quiet_ok}, 1);
    // R2 R4 R5: status kind
    check(st == es, es == 2'b10 ? "R4 cold miss status" :
                    es == 2'b11 ? "R5 replace status" : "R3 hit status", st, es);
    if (!we) check(rd == exp_rd, "R10 load data equals memory", rd, exp_rd);
    n_exp = (es != 2'b01 ? 4 : 0) + (we ? 1 : 0);
    check(op_addr.size() == n_exp, we ? "R9 memory op count" : "R6 memory op count",
          op_addr.size(), n_exp);
    if (op_addr.size() == n_exp) begin
      for (int i = 0; i < 4 && es != 2'b01; i++)
        check(!op_we[i] && op_addr[i] == {a[31:4], 2'(i), 2'b00},
              "R6 refill order", op_addr[i], {a[31:4], 2'(i), 2'b00});
      if (we)
        check(op_we[n_exp-1] && op_addr[n_exp-1] == {a[31:2], 2'b00} && op_data[n_exp-1] == wd,
              "R8 write-through", op_addr[n_exp-1], {a[31:2], 2'b00});
    end
    ref_valid[a[13:4]] = 1'b1;
    ref_tag[a[13:4]] = a[31:14];
  endtask

  initial begin
    int done_wd = 0;
    repeat (150000) @(posedge clk);
    if (done_wd == 0) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [1:0]  st;
    int          sel[6] = '{0, 1, 2, 3, 1022, 1023};
    void'($urandom(32'd4471));
    for (int i = 0; i < 1024; i++) begin ref_valid[i] = 1'b0; ref_tag[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(cpu_ready == 1'b0 && cpu_status == 2'b00 && mem_req == 1'b0, "R11 reset outputs",
          {cpu_ready, cpu_status, mem_req}, 0);
    rst_n = 1'b1;

    // directed: cold miss, same-block hit, another cold line, replacement
    access(1'b0, 32'h0000_0014, '0, rd, st);
    check(st == 2'b10, "R2 first access after reset is cold", st, 2'b10);
    access(1'b0, 32'h0000_001C, '0, rd, st);
    check(st == 2'b01, "R7 replayed block now hits", st, 2'b01);
    access(1'b0, 32'h0000_001F, '0, rd, st);
    check(rd == mem_rd(30'h7), "R1 low two bits ignored", rd, mem_rd(30'h7));
    access(1'b0, 32'h0000_0034, '0, rd, st);
    access(1'b0, 32'h0000_8014, '0, rd, st);
    check(st == 2'b11, "R5 tag conflict replaces", st, 2'b11);
    access(1'b0, 32'h0000_0030, '0, rd, st);
    check(st == 2'b01, "R3 other line survives", st, 2'b01);
    // store hit then readback
    access(1'b1, 32'h0000_8018, 32'hCAFE_0001, rd, st);
    check(st == 2'b01, "R8 store hit status", st, 2'b01);
    access(1'b0, 32'h0000_8018, '0, rd, st);
    check(rd == 32'hCAFE_0001, "R8 stored word read back", rd, 32'hCAFE_0001);
    // store miss (cold and replacing)
    access(1'b1, 32'h0000_3FF8, 32'h1234_5678, rd, st);
    check(st == 2'b10, "R9 store cold miss", st, 2'b10);
    access(1'b1, 32'h0001_0014, 32'h0BAD_F00D, rd, st);
    check(st == 2'b11, "R9 store replacing miss", st, 2'b11);
    access(1'b0, 32'h0001_0014, '0, rd, st);
    check(rd == 32'h0BAD_F00D && st == 2'b01, "R9 merged word after allocate", rd, 32'h0BAD_F00D);
    // old block reloaded from memory still shows the earlier store
    access(1'b0, 32'h0000_8018, '0, rd, st);
    check(rd == 32'hCAFE_0001, "R10 evicted store visible in memory", rd, 32'hCAFE_0001);

    // constrained random over colliding lines
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = {16'd0, 2'($urandom_range(0, 3)), 10'(sel[$urandom_range(0, 5)]),
           2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      access($urandom_range(0, 3) == 0, a, $urandom, rd, st);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule